// File: doc/BRIEF.md
# Receive Mailbox ID Matcher

This block decides which of a bank of receive mailboxes takes an incoming frame. On a one-cycle start pulse it compares the received identifier against the stored identifier of every mailbox that is marked as an active receive buffer. The compare is filtered by an acceptance mask. Two cycles later it pulses a done strobe together with a hit flag and the index of the chosen mailbox.

Two matching policies are available, chosen by a mode input. In individual mode every mailbox has its own mask. The winner is the lowest-index matching mailbox that is free. If every matching mailbox is full, the highest-index matching mailbox is chosen so that it can be overwritten. Frames can therefore queue across several mailboxes that share an identifier. In legacy mode two fixed mailboxes (14 and 15) each use a dedicated mask and all other mailboxes share one global mask. The first matching mailbox by index wins, whether it is free or full.

The block holds the mask storage and its write port. The per-mailbox masks have no reset. They can be written only in individual mode while the module is frozen. The three legacy masks reset to all ones and can be written at any time.

Top module: `rxid_matcher`

## Requirements
- R1: Where a mask bit is 1 the received and stored ID bits must be equal. Where it is 0 that bit is ignored.
- R2: Identifiers are 29 bits. A standard frame (`rx_ext_i`=0) compares only ID bits [28:18]. An extended frame compares all 29 bits. The received extended flag must equal the mailbox's `mb_ext_i` bit or there is no match.
- R3: A mailbox whose `mb_rx_act_i` bit is 0 never matches.
- R4: With `indiv_mode_i`=1 each mailbox uses its own mask, and the lowest-index matching mailbox whose `mb_free_i` bit is 1 wins.
- R5: With `indiv_mode_i`=1 and no matching mailbox free, the highest-index matching mailbox wins.
- R6: With `indiv_mode_i`=0 the lowest-index matching mailbox wins regardless of `mb_free_i`.
- R7: With `indiv_mode_i`=0, mailbox 14 uses the mask at write address 33 and mailbox 15 uses the mask at address 34. All other mailboxes use the global mask at address 32. These three masks are written on any cycle with `msk_we_i`=1.
- R8: A write to a per-mailbox mask (address 0..31 = mailbox number) takes effect only when `indiv_mode_i`=1 and `freeze_i`=1 in the write cycle. Otherwise the write is ignored.
- R9: A start sampled on clock edge k yields a one-cycle `done_o` after edge k+1, carrying `hit_o` and `idx_o`. With no match `hit_o`=0 and `idx_o`=0. While `done_o`=0, both `hit_o` and `idx_o` are 0.
- R10: After reset `done_o`, `hit_o` and `idx_o` are 0 and the three legacy masks are all ones. Per-mailbox masks are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a scan with the current inputs |
| rx_id_i | input | 29 | Received identifier |
| rx_ext_i | input | 1 | Received frame uses an extended ID |
| mb_id_i | input | 928 | Stored IDs, mailbox n at bits [29n+28:29n] |
| mb_ext_i | input | 32 | Stored extended-ID flag per mailbox |
| mb_rx_act_i | input | 32 | Mailbox is an active receive buffer |
| mb_free_i | input | 32 | Mailbox is free (1) or full (0) |
| indiv_mode_i | input | 1 | 1 = individual masks, 0 = legacy masks |
| freeze_i | input | 1 | Module is frozen |
| msk_we_i | input | 1 | Mask write enable |
| msk_addr_i | input | 6 | Mask address: 0..31 per mailbox, 32 global, 33 mailbox 14, 34 mailbox 15 |
| msk_data_i | input | 29 | Mask write data |
| done_o | output | 1 | Scan result strobe |
| hit_o | output | 1 | A mailbox matched |
| idx_o | output | 5 | Winning mailbox index |

## Verification
Mask writes take effect at the clock edge that samples them, so the bench waits at least one edge after a write before it starts a scan. A scan result is due one cycle after the edge that samples the start pulse. The bench drives start on a falling edge. On the following falling edge it checks that `done_o` is still low. One cycle later it compares `done_o`, `hit_o` and `idx_o` with values from its own model, and on the next falling edge it checks that the strobe has dropped. All inputs are held from the falling edge before start until after that sampling edge.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
    // Low bits of a legacy mask address (upper address bit set)
    typedef enum logic [1:0] {
        LMSK_GLOBAL = 2'd0,
        LMSK_DED_A  = 2'd1,
        LMSK_DED_B  = 2'd2
    } lmsk_sel_e;
endpackage

// File: rtl/rxm_mask_store.sv
module rxm_mask_store #(
    parameter int unsigned NUM_MB = 32,
    parameter int unsigned ID_W   = 29,
    parameter int unsigned AW     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [AW-1:0]          addr_i,
    input  logic [ID_W-1:0]        data_i,
    input  logic                   indiv_mode_i,
    input  logic                   freeze_i,
    output logic [NUM_MB*ID_W-1:0] ind_o,
    output logic [ID_W-1:0]        glob_o,
    output logic [ID_W-1:0]        ded_a_o,
    output logic [ID_W-1:0]        ded_b_o
);
    import rxm_pkg::*;

    localparam int unsigned IW = AW - 1;

    logic [ID_W-1:0] ind_q [NUM_MB];
    logic [ID_W-1:0] glob_q, ded_a_q, ded_b_q;
    logic            leg_sel, ind_ok;

    assign leg_sel = addr_i[AW-1];
    assign ind_ok  = we_i && !leg_sel && indiv_mode_i && freeze_i;

    // Per-mailbox masks: plain storage, no reset
    always_ff @(posedge clk) begin
        if (ind_ok) begin
            ind_q[addr_i[IW-1:0]] <= data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_q  <= '1;
            ded_a_q <= '1;
            ded_b_q <= '1;
        end else if (we_i && leg_sel) begin
            case (addr_i[1:0])
                LMSK_GLOBAL: glob_q  <= data_i;
                LMSK_DED_A:  ded_a_q <= data_i;
                LMSK_DED_B:  ded_b_q <= data_i;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_MB; g++) begin : g_flat
        assign ind_o[g*ID_W +: ID_W] = ind_q[g];
    end

    assign glob_o  = glob_q;
    assign ded_a_o = ded_a_q;
    assign ded_b_o = ded_b_q;
endmodule

// File: rtl/rxm_match_vec.sv
module rxm_match_vec #(
    parameter int unsigned NUM_MB = 32,
    parameter int unsigned ID_W   = 29,
    parameter int unsigned STD_W  = 11,
    parameter int unsigned DED_A  = 14,
    parameter int unsigned DED_B  = 15
) (
    input  logic [ID_W-1:0]        rx_id_i,
    input  logic                   rx_ext_i,
    input  logic [NUM_MB*ID_W-1:0] mb_id_i,
    input  logic [NUM_MB-1:0]      mb_ext_i,
    input  logic [NUM_MB-1:0]      mb_rx_act_i,
    input  logic                   indiv_mode_i,
    input  logic [NUM_MB*ID_W-1:0] ind_i,
    input  logic [ID_W-1:0]        glob_i,
    input  logic [ID_W-1:0]        ded_a_i,
    input  logic [ID_W-1:0]        ded_b_i,
    output logic [NUM_MB-1:0]      match_o
);
    localparam logic [ID_W-1:0] STD_SEL = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

    logic [ID_W-1:0] field_sel;
    assign field_sel = rx_ext_i ? '1 : STD_SEL;

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        logic [ID_W-1:0] leg_msk, msk, diff;
        if (g == DED_A) begin : g_a
            assign leg_msk = ded_a_i;
        end else if (g == DED_B) begin : g_b
            assign leg_msk = ded_b_i;
        end else begin : g_glob
            assign leg_msk = glob_i;
        end
        assign msk  = indiv_mode_i ? ind_i[g*ID_W +: ID_W] : leg_msk;
        assign diff = (rx_id_i ^ mb_id_i[g*ID_W +: ID_W]) & msk & field_sel;
        assign match_o[g] = mb_rx_act_i[g] && (rx_ext_i == mb_ext_i[g]) && (diff == '0);
    end
endmodule

// File: rtl/rxm_pick.sv
module rxm_pick #(
    parameter int unsigned NUM_MB = 32,
    parameter int unsigned IDX_W  = 5
) (
    input  logic [NUM_MB-1:0] match_i,
    input  logic [NUM_MB-1:0] free_i,
    input  logic              indiv_mode_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    logic [NUM_MB-1:0] avail;
    logic [IDX_W-1:0]  lo_avail, lo_match, hi_match;

    assign avail = match_i & free_i;

    always_comb begin
        lo_avail = '0;
        lo_match = '0;
        hi_match = '0;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (avail[i])   lo_avail = IDX_W'(i);
            if (match_i[i]) lo_match = IDX_W'(i);
        end
        for (int i = 0; i < NUM_MB; i++) begin
            if (match_i[i]) hi_match = IDX_W'(i);
        end
    end

    assign hit_o = |match_i;
    assign idx_o = !indiv_mode_i ? lo_match :
                   (|avail)      ? lo_avail : hi_match;
endmodule

// File: rtl/rxid_matcher.sv
module rxid_matcher #(
    parameter int unsigned NUM_MB = 32,
    parameter int unsigned ID_W   = 29,
    parameter int unsigned STD_W  = 11,
    parameter int unsigned DED_A  = 14,
    parameter int unsigned DED_B  = 15,
    localparam int unsigned IDX_W = $clog2(NUM_MB),
    localparam int unsigned AW    = IDX_W + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [ID_W-1:0]        rx_id_i,
    input  logic                   rx_ext_i,
    input  logic [NUM_MB*ID_W-1:0] mb_id_i,
    input  logic [NUM_MB-1:0]      mb_ext_i,
    input  logic [NUM_MB-1:0]      mb_rx_act_i,
    input  logic [NUM_MB-1:0]      mb_free_i,
    input  logic                   indiv_mode_i,
    input  logic                   freeze_i,
    input  logic                   msk_we_i,
    input  logic [AW-1:0]          msk_addr_i,
    input  logic [ID_W-1:0]        msk_data_i,
    output logic                   done_o,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       idx_o
);
    typedef struct packed {
        logic              s1_vld;
        logic              s1_mode;
        logic [NUM_MB-1:0] s1_match;
        logic [NUM_MB-1:0] s1_free;
        logic              done;
        logic              hit;
        logic [IDX_W-1:0]  idx;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_MB*ID_W-1:0] ind_msk;
    logic [ID_W-1:0]        glob_msk, ded_a_msk, ded_b_msk;
    logic [NUM_MB-1:0]      match_vec;
    logic                   pick_hit;
    logic [IDX_W-1:0]       pick_idx;

    rxm_mask_store #(.NUM_MB(NUM_MB), .ID_W(ID_W), .AW(AW)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (msk_we_i),
        .addr_i       (msk_addr_i),
        .data_i       (msk_data_i),
        .indiv_mode_i (indiv_mode_i),
        .freeze_i     (freeze_i),
        .ind_o        (ind_msk),
        .glob_o       (glob_msk),
        .ded_a_o      (ded_a_msk),
        .ded_b_o      (ded_b_msk)
    );

    rxm_match_vec #(
        .NUM_MB(NUM_MB), .ID_W(ID_W), .STD_W(STD_W), .DED_A(DED_A), .DED_B(DED_B)
    ) u_match (
        .rx_id_i      (rx_id_i),
        .rx_ext_i     (rx_ext_i),
        .mb_id_i      (mb_id_i),
        .mb_ext_i     (mb_ext_i),
        .mb_rx_act_i  (mb_rx_act_i),
        .indiv_mode_i (indiv_mode_i),
        .ind_i        (ind_msk),
        .glob_i       (glob_msk),
        .ded_a_i      (ded_a_msk),
        .ded_b_i      (ded_b_msk),
        .match_o      (match_vec)
    );

    rxm_pick #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_pick (
        .match_i      (st_q.s1_match),
        .free_i       (st_q.s1_free),
        .indiv_mode_i (st_q.s1_mode),
        .hit_o        (pick_hit),
        .idx_o        (pick_idx)
    );

    always_comb begin
        st_d          = st_q;
        st_d.s1_vld   = start_i;
        st_d.s1_mode  = indiv_mode_i;
        st_d.s1_match = start_i ? match_vec : '0;
        st_d.s1_free  = mb_free_i;
        st_d.done     = st_q.s1_vld;
        st_d.hit      = st_q.s1_vld && pick_hit;
        st_d.idx      = (st_q.s1_vld && pick_hit) ? pick_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign hit_o  = st_q.hit;
    assign idx_o  = st_q.idx;
endmodule

// File: rtl/rxid_matcher_chk.sv
module rxid_matcher_chk #(
    parameter int unsigned IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             done_o,
    input logic             hit_o,
    input logic [IDX_W-1:0] idx_o
);
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ##1 done_o);                                   // R9
    AST_DONE_HAS_START: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i, 2));                             // R9
    AST_HIT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> done_o);                                         // R9
    AST_IDX_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> idx_o == '0);                                   // R9
endmodule

bind rxid_matcher rxid_matcher_chk #(.IDX_W(IDX_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .done_o  (done_o),
    .hit_o   (hit_o),
    .idx_o   (idx_o)
);

// File: tb/rxid_matcher_tb.sv
module rxid_matcher_tb;
    localparam int  NMB   = 32;
    localparam int  IW    = 29;
    localparam time CLK_P = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [IW-1:0] rx_id_i = '0;
    logic          rx_ext_i = 1'b0;
    logic [NMB*IW-1:0] mb_id_i;
    logic [NMB-1:0] mb_ext_i = '0, mb_rx_act_i = '0, mb_free_i = '0;
    logic          indiv_mode_i = 1'b0, freeze_i = 1'b0, msk_we_i = 1'b0;
    logic [5:0]    msk_addr_i = '0;
    logic [IW-1:0] msk_data_i = '0;
    logic          done_o, hit_o;
    logic [4:0]    idx_o;

    logic [IW-1:0] m_id [NMB];
    logic [IW-1:0] m_ind [NMB];
    logic [IW-1:0] m_glob = '1, m_a = '1, m_b = '1;
    int checks = 0, fails = 0;

    always #(CLK_P/2) clk = ~clk;

    always_comb for (int i = 0; i < NMB; i++) mb_id_i[i*IW +: IW] = m_id[i];

    rxid_matcher u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_mask(input logic [5:0] a, input logic [IW-1:0] d);
        @(negedge clk);
        msk_we_i = 1'b1; msk_addr_i = a; msk_data_i = d;
        if (a >= 6'd32) begin
            if (a == 6'd32) m_glob = d;
            else if (a == 6'd33) m_a = d;
            else if (a == 6'd34) m_b = d;
        end else if (indiv_mode_i && freeze_i) m_ind[a] = d;
        @(negedge clk);
        msk_we_i = 1'b0;
    endtask

    function automatic logic [IW-1:0] sel_mask(input int i);
        if (indiv_mode_i) return m_ind[i];
        if (i == 14) return m_a;
        if (i == 15) return m_b;
        return m_glob;
    endfunction

    function automatic logic [5:0] model();   // {hit, idx}
        logic [NMB-1:0] m;
        logic [IW-1:0]  fs, d;
        int lo_f, lo_m, hi_m;
        fs = rx_ext_i ? '1 : {{11{1'b1}}, {18{1'b0}}};
        lo_f = -1; lo_m = -1; hi_m = -1;
        for (int i = 0; i < NMB; i++) begin
            d = (rx_id_i ^ m_id[i]) & sel_mask(i) & fs;
            m[i] = mb_rx_act_i[i] && (mb_ext_i[i] == rx_ext_i) && (d == '0);
            if (m[i]) begin
                if (lo_m < 0) lo_m = i;
                hi_m = i;
                if (mb_free_i[i] && lo_f < 0) lo_f = i;
            end
        end
        if (lo_m < 0) return 6'd0;
        if (!indiv_mode_i) return {1'b1, 5'(lo_m)};
        return {1'b1, 5'(lo_f >= 0 ? lo_f : hi_m)};
    endfunction

    task automatic scan(input string req);
        logic [5:0] e;
        e = model();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk({req, " done early"}, 32'(done_o), 32'd0);
        @(negedge clk);
        chk({req, " done"}, 32'(done_o), 32'd1);
        chk({req, " hit"}, 32'(hit_o), 32'(e[5]));
        chk({req, " idx"}, 32'(idx_o), 32'(e[4:0]));
        @(negedge clk);
        chk({req, " done drop"}, 32'(done_o), 32'd0);
    endtask

    task automatic clr_bank();
        for (int i = 0; i < NMB; i++) m_id[i] = IW'(i + 1000);
        mb_ext_i = '0; mb_rx_act_i = '0; mb_free_i = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        clr_bank();
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 done", 32'(done_o), 0);
        chk("R10 hit", 32'(hit_o), 0);
        chk("R10 idx", 32'(idx_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 legacy masks all ones: exact compare in legacy mode
        m_id[3] = 29'h1234567; mb_rx_act_i[3] = 1'b1; mb_ext_i[3] = 1'b1;
        rx_ext_i = 1'b1; rx_id_i = 29'h1234566;
        scan("R10 legacy mask ones");
        rx_id_i = 29'h1234567;
        scan("R10 exact hit");

        // Initialise per-mailbox masks (R8 write path)
        indiv_mode_i = 1'b1; freeze_i = 1'b1;
        for (int i = 0; i < NMB; i++) wr_mask(6'(i), '1);
        freeze_i = 1'b0;

        // R8: write outside freeze is ignored
        clr_bank();
        m_id[5] = 29'h0AAAAAA; mb_rx_act_i[5] = 1'b1; mb_ext_i[5] = 1'b1;
        rx_id_i = 29'h1555555; rx_ext_i = 1'b1;
        wr_mask(6'd5, '0);
        @(negedge clk);
        scan("R8 no-freeze write ignored");
        indiv_mode_i = 1'b0; freeze_i = 1'b1;
        wr_mask(6'd5, '0);
        indiv_mode_i = 1'b1;
        @(negedge clk);
        scan("R8 legacy-mode write ignored");
        wr_mask(6'd5, '0);
        @(negedge clk);
        scan("R8 frozen write applied");
        // R1: mask bit 0 is don't-care, bit 1 must match
        wr_mask(6'd5, 29'h0000F00);
        rx_id_i = 29'h0AAAAAA ^ 29'h00000FF;
        @(negedge clk);
        scan("R1 dont-care bits");
        rx_id_i = 29'h0AAAAAA ^ 29'h0000100;
        scan("R1 care bit differs");
        wr_mask(6'd5, '1);

        // R2: standard frames compare upper 11 bits only; ext flag exact
        mb_ext_i[5] = 1'b0; rx_ext_i = 1'b0;
        rx_id_i = {m_id[5][28:18], 18'h3FFFF};
        @(negedge clk);
        scan("R2 std low bits ignored");
        rx_id_i = m_id[5] ^ 29'h0040000;
        scan("R2 std bit 18 compared");
        rx_id_i = m_id[5]; rx_ext_i = 1'b1;
        scan("R2 ext flag mismatch");

        // R3/R4/R5 queueing in individual mode
        clr_bank();
        for (int i = 4; i < 9; i++) m_id[i] = 29'h0ABCDEF;
        m_id[20] = 29'h0ABCDEF;
        mb_ext_i = '1; rx_ext_i = 1'b1; rx_id_i = 29'h0ABCDEF;
        mb_rx_act_i[4] = 1'b0; mb_rx_act_i[8:5] = '1; mb_free_i = '1;
        scan("R3 inactive skipped R4 lowest free");
        mb_free_i[5] = 1'b0; mb_free_i[6] = 1'b0;
        scan("R4 lowest free past full");
        mb_free_i = '0; mb_rx_act_i[20] = 1'b1;
        scan("R5 all full highest");
        mb_rx_act_i = '0;
        scan("R3 none active");

        // R6/R7 legacy mode
        indiv_mode_i = 1'b0; freeze_i = 1'b0;
        clr_bank();
        m_id[14] = 29'h1000000; m_id[15] = 29'h1000000; m_id[20] = 29'h1000000;
        mb_ext_i = '1; mb_rx_act_i = '1;
        wr_mask(6'd33, 29'h1000001);
        wr_mask(6'd34, 29'h1000000);
        wr_mask(6'd32, 29'h1000000);
        rx_id_i = 29'h1000001;
        @(negedge clk);
        scan("R7 mailbox 14 own mask R6 full ok");
        wr_mask(6'd33, '1);
        wr_mask(6'd34, 29'h1000001);
        @(negedge clk);
        scan("R7 global mask skips 15 to 20");
        wr_mask(6'd34, 29'h0000000);
        mb_free_i = '1; mb_free_i[14] = 1'b0;
        @(negedge clk);
        scan("R6 first hit not queue aware");
        wr_mask(6'd32, '1); wr_mask(6'd33, '1); wr_mask(6'd34, '1);

        // Constrained random mix in both modes
        for (int n = 0; n < 300; n++) begin
            logic [IW-1:0] pool [4];
            pool[0] = 29'h0123456; pool[1] = 29'h0123457;
            pool[2] = 29'h1F00000; pool[3] = 29'h0003456;
            indiv_mode_i = $urandom_range(0, 1) != 0;
            if ($urandom_range(0, 9) == 0) begin
                freeze_i = 1'b1;
                wr_mask(6'($urandom_range(0, 34)),
                        $urandom_range(0, 1) != 0 ? '1 : IW'($urandom));
                freeze_i = 1'b0;
            end
            for (int i = 0; i < NMB; i++) m_id[i] = pool[$urandom_range(0, 3)];
            mb_ext_i = $urandom | $urandom;
            mb_rx_act_i = $urandom | $urandom;
            mb_free_i = $urandom & $urandom;
            rx_id_i = pool[$urandom_range(0, 3)];
            rx_ext_i = $urandom_range(0, 3) != 0;
            @(negedge clk);
            scan(indiv_mode_i ? "R4 R5 R1 random" : "R6 R7 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule